// File: doc/BRIEF.md
# CAN Message Buffer Controller

This block holds an array of CAN message buffers and the interrupt flags that go with them. Each buffer has four 32-bit words: a control word (a 4-bit code, a 4-bit length, and the SRR, IDE and RTR bits), an identifier word and two data words. Software reaches all of them through a simple memory-mapped bus. A frame-level transmit port offers a frame whenever a buffer is armed for sending. A frame-level receive port stores each incoming frame into a single buffer. Bit timing, arbitration on the wire and acceptance filtering belong to other blocks.

Every buffer runs its own code-driven state machine. The states are receive-off (0x0), receive-empty (0x4), receive-full (0x2), receive-overrun (0x6), transmit-off (0x8) and transmit-send (0xC). The transitions are:
- Any state goes to the decoded written code when the control word is written. The command code 0x9 decodes to transmit-off, and any code outside the list decodes to receive-off.
- Receive-empty goes to receive-full when a frame is stored.
- Receive-full and receive-overrun go to receive-overrun when a further frame is stored.
- Transmit-send goes to transmit-off when the frame is accepted on the transmit port.
- Receive-off and transmit-off hold their state without a bus write.

Reading a control word locks that buffer against reception. Reading the timer register releases the lock.

Top module: `can_mb_ctrl`

## Requirements
- R1: Byte addressing. Word k of buffer n sits at 0x400 + 0x10*n + 4*k. Flag register low (buffers 0-31) is at 0x000, flag register high (buffers 32-63) at 0x004, the free-running timer at 0x008, and the configuration register at 0x00C, whose bit 0 disables self-reception. A read returns its data on bus_rdata with bus_rvalid high in the cycle after bus_re.
- R2: After reset every buffer word reads 0, so every code is receive-off, and both flag registers read 0.
- R3: Writing code 0xC makes tx_valid present the frame. When tx_valid and tx_ready are both high, the code becomes 0x8, the buffer's flag is set, and the length, SRR, IDE, RTR, identifier and data words keep their values.
- R4: A standard identifier lives in identifier-word bits 28:18, and an extended identifier in bits 28:0. tx_id and rx_id carry the 11-bit or 29-bit value right-aligned, selected by IDE.
- R5: A stored frame sets the code to 0x2, sets SRR, copies length, IDE and RTR, writes the identifier word in the R4 layout, writes both data words, and sets the buffer's flag.
- R6: When no unlocked empty buffer exists, the frame goes to the lowest-numbered unlocked full or overrun buffer, whose code becomes 0x6.
- R7: Writing command code 0x9 makes the buffer read back code 0x8, withdraws the pending frame from tx_valid, and sets no flag.
- R8: With configuration bit 0 clear, a frame accepted on the transmit port is also stored as if it had been received. With the bit set, it is not stored. rx_ready is low in the cycle a self-received frame is stored, and an external frame offered in that cycle is dropped.
- R9: A read of a control word locks that buffer, and a locked buffer never stores a frame. A read of the timer register releases the lock.
- R10: Receive-off buffers never store frames. Each frame fills exactly one buffer, and it is the lowest-numbered unlocked empty one.
- R11: A flag register bit written with 1 clears. Bits written with 0 keep their value, and a set in the same cycle wins over a clear.
- R12: The control word layout is code 27:24, SRR 22, IDE 21, RTR 20, length 19:16. All other bits read 0. An unlisted written code is stored as 0x0.
- R13: When several buffers hold code 0xC, the lowest-numbered one is presented first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| tx_valid | output | 1 | A frame is offered for sending |
| tx_ready | input | 1 | The offered frame is taken this cycle |
| tx_buf | output | 6 | Buffer index of the offered frame |
| tx_id | output | 29 | Right-aligned identifier of the offered frame |
| tx_ide | output | 1 | Offered frame uses an extended identifier |
| tx_rtr | output | 1 | Offered frame is a remote request |
| tx_len | output | 4 | Offered frame length |
| tx_data0 | output | 32 | First data word |
| tx_data1 | output | 32 | Second data word |
| rx_valid | input | 1 | An incoming frame is presented |
| rx_ready | output | 1 | Low when a self-received frame occupies the store path |
| rx_id | input | 29 | Right-aligned identifier of the incoming frame |
| rx_ide | input | 1 | Incoming frame uses an extended identifier |
| rx_rtr | input | 1 | Incoming frame is a remote request |
| rx_len | input | 4 | Incoming frame length |
| rx_data0 | input | 32 | First data word |
| rx_data1 | input | 32 | Second data word |

## Verification
The bench attacks the buffer-choice rules in several ways:
- It locks the lowest empty buffer and expects the frame to land in the next one. A design that ignores the lock would overwrite a buffer software is reading.
- It leaves no empty buffer and expects the lowest full one to become overrun. A design that drops or misplaces the frame would lose the overrun indication.
- It reads back untouched receive-off neighbours. A design that floods every candidate would show data there.

It arms a buffer and then aborts it, to catch designs that still send or set a flag. It sends a frame with self-reception both on and off, to catch designs that skip the loopback copy or ignore the disable bit. It writes all-ones control words, to catch designs that leak unimplemented bits or store undefined codes.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [3:0] {
        MB_RX_OFF   = 4'h0,
        MB_RX_FULL  = 4'h2,
        MB_RX_EMPTY = 4'h4,
        MB_RX_OVR   = 4'h6,
        MB_TX_OFF   = 4'h8,
        MB_TX_SEND  = 4'hC
    } mb_code_e;

    localparam logic [3:0] CMD_ABORT = 4'h9;

    // Map a code written over the bus onto a buffer state (R12, R7)
    function automatic mb_code_e decode_code(input logic [3:0] raw);
        mb_code_e c;
        unique case (raw)
            4'h2:      c = MB_RX_FULL;
            4'h4:      c = MB_RX_EMPTY;
            4'h6:      c = MB_RX_OVR;
            4'h8:      c = MB_TX_OFF;
            CMD_ABORT: c = MB_TX_OFF;
            4'hC:      c = MB_TX_SEND;
            default:   c = MB_RX_OFF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mbc_pick.sv
// Lowest-index priority encoder
module mbc_pick #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/mbc_slot.sv
// Per-buffer code state machine
module mbc_slot
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_code,
    input  logic       rx_hit,
    input  logic       tx_done,
    output mb_code_e   code,
    output logic       is_empty,
    output logic       is_filled,
    output logic       is_armed
);
    mb_code_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= MB_RX_OFF;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (wr_en) begin
            nxt = decode_code(wr_code);
        end else begin
            unique case (cur_q)
                MB_RX_EMPTY:          if (rx_hit)  nxt = MB_RX_FULL;
                MB_RX_FULL, MB_RX_OVR: if (rx_hit) nxt = MB_RX_OVR;
                MB_TX_SEND:           if (tx_done) nxt = MB_TX_OFF;
                MB_RX_OFF, MB_TX_OFF: nxt = cur_q;
            endcase
        end
    end

    always_comb begin
        code      = cur_q;
        is_empty  = (cur_q == MB_RX_EMPTY);
        is_filled = (cur_q == MB_RX_FULL) || (cur_q == MB_RX_OVR);
        is_armed  = (cur_q == MB_TX_SEND);
    end

    AST_EMPTY_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == MB_RX_EMPTY && rx_hit && !wr_en) |=> (cur_q == MB_RX_FULL)); // R5
    AST_FULL_TO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == MB_RX_FULL && rx_hit && !wr_en) |=> (cur_q == MB_RX_OVR)); // R6
    AST_SEND_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == MB_TX_SEND && tx_done && !wr_en) |=> (cur_q == MB_TX_OFF)); // R3
    AST_RX_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == MB_RX_OFF && !wr_en) |=> (cur_q == MB_RX_OFF)); // R10
endmodule

// File: rtl/can_mb_ctrl.sv
module can_mb_ctrl
    import mbc_pkg::*;
#(
    parameter int NUM_BUF = 64,
    parameter int ADDR_W  = 12,
    parameter int TIMER_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [5:0]  tx_buf,
    output logic [28:0] tx_id,
    output logic        tx_ide,
    output logic        tx_rtr,
    output logic [3:0]  tx_len,
    output logic [31:0] tx_data0,
    output logic [31:0] tx_data1,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [28:0] rx_id,
    input  logic        rx_ide,
    input  logic        rx_rtr,
    input  logic [3:0]  rx_len,
    input  logic [31:0] rx_data0,
    input  logic [31:0] rx_data1
);
    localparam int IDX_W  = $clog2(NUM_BUF);
    localparam int FLAG_W = 64;
    localparam int SEL_W  = ADDR_W - IDX_W - 4;
    localparam logic [SEL_W-1:0] MB_SEL = SEL_W'(1);

    // ---------------- address decode (R1)
    logic             in_mb, in_reg;
    logic [IDX_W-1:0] mb_idx;
    logic [1:0]       mb_word, reg_no;

    always_comb begin
        in_mb   = (bus_addr[ADDR_W-1:IDX_W+4] == MB_SEL);
        in_reg  = (bus_addr[ADDR_W-1:4] == '0);
        mb_idx  = bus_addr[IDX_W+3:4];
        mb_word = bus_addr[3:2];
        reg_no  = bus_addr[3:2];
    end

    // ---------------- per-buffer state
    mb_code_e     code_arr [NUM_BUF];
    logic [NUM_BUF-1:0] empty_vec, filled_vec, armed_vec, ctrl_wr_vec;
    logic [NUM_BUF-1:0] rx_hit_vec, tx_done_vec, lock_vec;

    logic [3:0]  len_q  [NUM_BUF];
    logic        srr_q  [NUM_BUF];
    logic        ide_q  [NUM_BUF];
    logic        rtr_q  [NUM_BUF];
    logic [31:0] id_q   [NUM_BUF];
    logic [31:0] d0_q   [NUM_BUF];
    logic [31:0] d1_q   [NUM_BUF];

    logic               lock_v;
    logic [IDX_W-1:0]   lock_idx;
    logic               cfg_self_dis;
    logic [FLAG_W-1:0]  flags_q;
    logic [TIMER_W-1:0] timer_q;

    genvar g;
    generate
        for (g = 0; g < NUM_BUF; g++) begin : g_slot
            assign ctrl_wr_vec[g] = bus_we && in_mb && (mb_word == 2'd0) && (mb_idx == IDX_W'(g));
            assign lock_vec[g]    = lock_v && (lock_idx == IDX_W'(g));
            mbc_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ctrl_wr_vec[g]),
                .wr_code  (bus_wdata[27:24]),
                .rx_hit   (rx_hit_vec[g]),
                .tx_done  (tx_done_vec[g]),
                .code     (code_arr[g]),
                .is_empty (empty_vec[g]),
                .is_filled(filled_vec[g]),
                .is_armed (armed_vec[g])
            );
        end
    endgenerate

    // ---------------- transmit selection (R3, R13)
    logic             tx_found, tx_fire;
    logic [IDX_W-1:0] tx_idx;

    mbc_pick #(.N(NUM_BUF), .W(IDX_W)) u_pick_tx (
        .req(armed_vec), .found(tx_found), .idx(tx_idx));

    always_comb begin
        tx_valid = tx_found;
        tx_buf   = 6'(tx_idx);
        tx_ide   = ide_q[tx_idx];
        tx_rtr   = rtr_q[tx_idx];
        tx_len   = len_q[tx_idx];
        tx_data0 = d0_q[tx_idx];
        tx_data1 = d1_q[tx_idx];
        tx_id    = tx_ide ? id_q[tx_idx][28:0] : {18'd0, id_q[tx_idx][28:18]};
        tx_fire  = tx_found && tx_ready;
        tx_done_vec = '0;
        if (tx_fire) tx_done_vec[tx_idx] = 1'b1;
    end

    // ---------------- receive selection (R5, R6, R8, R9, R10)
    logic             self_rx, frame_in;
    logic [28:0]      f_id;
    logic             f_ide, f_rtr;
    logic [3:0]       f_len;
    logic [31:0]      f_d0, f_d1;
    logic             e_found, o_found, rx_store;
    logic [IDX_W-1:0] e_idx, o_idx, rx_idx;

    mbc_pick #(.N(NUM_BUF), .W(IDX_W)) u_pick_empty (
        .req(empty_vec & ~lock_vec), .found(e_found), .idx(e_idx));
    mbc_pick #(.N(NUM_BUF), .W(IDX_W)) u_pick_over (
        .req(filled_vec & ~lock_vec), .found(o_found), .idx(o_idx));

    always_comb begin
        self_rx  = tx_fire && !cfg_self_dis;
        rx_ready = !self_rx;
        frame_in = self_rx || rx_valid;
        f_id  = self_rx ? tx_id    : rx_id;
        f_ide = self_rx ? tx_ide   : rx_ide;
        f_rtr = self_rx ? tx_rtr   : rx_rtr;
        f_len = self_rx ? tx_len   : rx_len;
        f_d0  = self_rx ? tx_data0 : rx_data0;
        f_d1  = self_rx ? tx_data1 : rx_data1;
        rx_store = frame_in && (e_found || o_found);
        rx_idx   = e_found ? e_idx : o_idx;
        rx_hit_vec = '0;
        if (rx_store) rx_hit_vec[rx_idx] = 1'b1;
    end

    // ---------------- buffer fields (bus write applied after frame store)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) begin
                len_q[i] <= '0; srr_q[i] <= 1'b0; ide_q[i] <= 1'b0; rtr_q[i] <= 1'b0;
                id_q[i]  <= '0; d0_q[i]  <= '0;   d1_q[i]  <= '0;
            end
        end else begin
            if (rx_store) begin
                len_q[rx_idx] <= f_len;
                srr_q[rx_idx] <= 1'b1;
                ide_q[rx_idx] <= f_ide;
                rtr_q[rx_idx] <= f_rtr;
                id_q[rx_idx]  <= f_ide ? {3'd0, f_id} : {3'd0, f_id[10:0], 18'd0};
                d0_q[rx_idx]  <= f_d0;
                d1_q[rx_idx]  <= f_d1;
            end
            if (bus_we && in_mb) begin
                unique case (mb_word)
                    2'd0: begin
                        srr_q[mb_idx] <= bus_wdata[22];
                        ide_q[mb_idx] <= bus_wdata[21];
                        rtr_q[mb_idx] <= bus_wdata[20];
                        len_q[mb_idx] <= bus_wdata[19:16];
                    end
                    2'd1: id_q[mb_idx] <= bus_wdata;
                    2'd2: d0_q[mb_idx] <= bus_wdata;
                    2'd3: d1_q[mb_idx] <= bus_wdata;
                endcase
            end
        end
    end

    // ---------------- flags, timer, lock, config (R9, R11)
    logic [FLAG_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[NUM_BUF-1:0] = rx_hit_vec | tx_done_vec;
        clr_vec = '0;
        if (bus_we && in_reg && reg_no == 2'd0) clr_vec[31:0]  = bus_wdata;
        if (bus_we && in_reg && reg_no == 2'd1) clr_vec[63:32] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q      <= '0;
            timer_q      <= '0;
            lock_v       <= 1'b0;
            lock_idx     <= '0;
            cfg_self_dis <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            timer_q <= timer_q + 1'b1;
            if (bus_re && in_mb && mb_word == 2'd0) begin
                lock_v   <= 1'b1;
                lock_idx <= mb_idx;
            end else if (bus_re && in_reg && reg_no == 2'd2) begin
                lock_v <= 1'b0;
            end
            if (bus_we && in_reg && reg_no == 2'd3) cfg_self_dis <= bus_wdata[0];
        end
    end

    // ---------------- read path (R1, R12)
    logic [31:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (in_mb) begin
            unique case (mb_word)
                2'd0: rd_mux = {4'd0, code_arr[mb_idx], 1'b0, srr_q[mb_idx],
                                ide_q[mb_idx], rtr_q[mb_idx], len_q[mb_idx], 16'd0};
                2'd1: rd_mux = id_q[mb_idx];
                2'd2: rd_mux = d0_q[mb_idx];
                2'd3: rd_mux = d1_q[mb_idx];
            endcase
        end else if (in_reg) begin
            unique case (reg_no)
                2'd0: rd_mux = flags_q[31:0];
                2'd1: rd_mux = flags_q[63:32];
                2'd2: rd_mux = 32'(timer_q);
                2'd3: rd_mux = {31'd0, cfg_self_dis};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_re;
            if (bus_re) bus_rdata <= rd_mux;
        end
    end

    AST_TX_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (code_arr[tx_idx] == MB_TX_SEND)); // R3
    AST_NO_LOCKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> !(lock_v && rx_idx == lock_idx)); // R9
    AST_NO_STORE_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> (code_arr[rx_idx] != MB_RX_OFF)); // R10
    AST_FLAG_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> flags_q[$past(tx_idx)]); // R11
endmodule

// File: tb/can_mb_ctrl_test.sv
`timescale 1ns/1ps
module can_mb_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_valid, tx_ready = 1'b0;
    logic [5:0]  tx_buf;
    logic [28:0] tx_id;
    logic        tx_ide, tx_rtr;
    logic [3:0]  tx_len;
    logic [31:0] tx_data0, tx_data1;
    logic        rx_valid = 1'b0, rx_ready;
    logic [28:0] rx_id = '0;
    logic        rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [3:0]  rx_len = '0;
    logic [31:0] rx_data0 = '0, rx_data1 = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    logic [31:0] msk_q[$];
    int          req_q[$];

    always #2.5 clk = ~clk;

    can_mb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_buf(tx_buf), .tx_id(tx_id),
        .tx_ide(tx_ide), .tx_rtr(tx_rtr), .tx_len(tx_len), .tx_data0(tx_data0),
        .tx_data1(tx_data1), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_id(rx_id),
        .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_len(rx_len), .rx_data0(rx_data0),
        .rx_data1(rx_data1)
    );

    function automatic logic [11:0] mb(input int n, input int k);
        return 12'(32'h400 + 16 * n + 4 * k);
    endfunction

    function automatic logic [31:0] ctl(input logic [3:0] c, input bit s, input bit e,
                                        input bit r, input logic [3:0] l);
        return {4'h0, c, 1'b0, s, e, r, l, 16'h0};
    endfunction

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, 1, bus_rdata, 32'hx);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic logic [31:0] m = msk_q.pop_front();
                automatic int r = req_q.pop_front();
                check((bus_rdata & m) == (e & m), r, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        exp_q.push_back(e); msk_q.push_back(32'hFFFF_FFFF); req_q.push_back(req);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic unlock;  // timer read releases the lock (R9)
        @(negedge clk);
        exp_q.push_back(32'h0); msk_q.push_back(32'h0); req_q.push_back(9);
        bus_re = 1'b1; bus_addr = 12'h008;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic tx_take(input int b, input logic [28:0] id, input bit e, input logic [3:0] l,
                           input logic [31:0] d0, input int req);
        @(negedge clk);
        check(tx_valid == 1'b1, req, 32'(tx_valid), 32'd1);
        check(tx_buf == 6'(b), req, 32'(tx_buf), 32'(b));
        check(tx_id == id && tx_ide == e, req, 32'(tx_id), 32'(id));
        check(tx_len == l && tx_data0 == d0, req, tx_data0, d0);
        tx_ready = 1'b1;
        @(posedge clk); #1;
        tx_ready = 1'b0;
    endtask

    task automatic rx_send(input logic [28:0] id, input bit e, input bit r, input logic [3:0] l,
                           input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = id; rx_ide = e; rx_rtr = r; rx_len = l;
        rx_data0 = d0; rx_data1 = d1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1: watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state, R1 map
        rd(12'h000, 32'h0, 2);
        rd(12'h004, 32'h0, 2);
        rd(mb(7, 0), 32'h0, 2);
        rd(mb(7, 1), 32'h0, 2);
        rd(12'h00C, 32'h0, 1);
        unlock();

        // R3 extended transmit on buffer 5, R4 layout
        wr(mb(5, 1), 32'h105AF5AF);
        wr(mb(5, 2), 32'h01020304);
        wr(mb(5, 3), 32'h0A0B0C0D);
        wr(mb(5, 0), ctl(4'hC, 1, 1, 0, 4'd8));
        tx_take(5, 29'h105AF5AF, 1, 4'd8, 32'h01020304, 3);
        rd(mb(5, 0), ctl(4'h8, 1, 1, 0, 4'd8), 3);
        rd(mb(5, 1), 32'h105AF5AF, 3);
        rd(mb(5, 3), 32'h0A0B0C0D, 3);
        rd(12'h000, 32'h1 << 5, 3);

        // R4 standard id on buffer 40, R11 high flag register and W1C
        wr(mb(40, 1), 32'h5AF << 18);
        wr(mb(40, 2), 32'hCAFEF00D);
        wr(mb(40, 0), ctl(4'hC, 0, 0, 0, 4'd4));
        tx_take(40, 29'h5AF, 0, 4'd4, 32'hCAFEF00D, 4);
        rd(12'h004, 32'h1 << 8, 11);
        wr(12'h000, 32'h1 << 5);
        rd(12'h000, 32'h0, 11);
        rd(12'h004, 32'h1 << 8, 11);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, 32'h0, 11);

        // R13 lowest armed buffer goes first
        wr(mb(30, 1), 32'h100 << 18);
        wr(mb(30, 0), ctl(4'hC, 0, 0, 0, 4'd1));
        wr(mb(25, 1), 32'h200 << 18);
        wr(mb(25, 0), ctl(4'hC, 0, 0, 0, 4'd1));
        tx_take(25, 29'h200, 0, 4'd1, 32'h0, 13);
        tx_take(30, 29'h100, 0, 4'd1, 32'h0, 13);
        rd(12'h000, (32'h1 << 25) | (32'h1 << 30), 13);
        wr(12'h000, 32'hFFFF_FFFF);

        // R5 and R10 reception into one empty buffer
        wr(mb(3, 0), 32'h0400_0000);
        wr(mb(9, 0), 32'h0400_0000);
        unlock();
        rx_send(29'h105AF5AF, 1, 0, 4'd8, 32'h01020304, 32'h0A0B0C0D);
        rd(mb(3, 0), ctl(4'h2, 1, 1, 0, 4'd8), 5);
        rd(mb(3, 1), 32'h105AF5AF, 5);
        rd(mb(3, 2), 32'h01020304, 5);
        rd(mb(3, 3), 32'h0A0B0C0D, 5);
        rd(mb(12, 0), 32'h0, 10);
        rd(mb(12, 1), 32'h0, 10);
        rd(mb(9, 0), 32'h0400_0000, 10);
        rd(12'h000, 32'h1 << 3, 5);

        // R9 locked buffer 9 skipped, then released
        wr(mb(10, 0), 32'h0400_0000);
        rd(mb(9, 0), 32'h0400_0000, 9);
        rx_send(29'h123, 0, 1, 4'd2, 32'h11111111, 32'h22222222);
        rd(mb(10, 0), ctl(4'h2, 1, 0, 1, 4'd2), 9);
        rd(mb(10, 1), 32'h123 << 18, 4);
        unlock();
        rx_send(29'h1ABCDE, 1, 0, 4'd3, 32'h33333333, 32'h44444444);
        rd(mb(9, 0), ctl(4'h2, 1, 1, 0, 4'd3), 9);
        rd(mb(9, 1), 32'h1ABCDE, 9);
        unlock();

        // R6 overrun into lowest full buffer
        rx_send(29'h0777, 0, 0, 4'd6, 32'h55555555, 32'h66666666);
        rd(mb(3, 0), ctl(4'h6, 1, 0, 0, 4'd6), 6);
        rd(mb(3, 1), 32'h0777 << 18, 6);
        rd(mb(3, 2), 32'h55555555, 6);
        unlock();
        wr(12'h000, 32'hFFFF_FFFF);

        // R8 self-reception enabled
        wr(mb(14, 0), 32'h0400_0000);
        wr(mb(50, 1), 32'h00ABCDEF);
        wr(mb(50, 2), 32'h77777777);
        wr(mb(50, 0), ctl(4'hC, 1, 1, 0, 4'd5));
        tx_take(50, 29'h00ABCDEF, 1, 4'd5, 32'h77777777, 8);
        rd(mb(14, 0), ctl(4'h2, 1, 1, 0, 4'd5), 8);
        rd(mb(14, 1), 32'h00ABCDEF, 8);
        rd(mb(14, 2), 32'h77777777, 8);
        rd(12'h000, 32'h1 << 14, 8);
        rd(12'h004, 32'h1 << 18, 8);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        unlock();

        // R8 self-reception disabled
        wr(12'h00C, 32'h1);
        rd(12'h00C, 32'h1, 8);
        wr(mb(15, 0), 32'h0400_0000);
        wr(mb(51, 1), 32'h00012345);
        wr(mb(51, 0), ctl(4'hC, 1, 1, 0, 4'd2));
        tx_take(51, 29'h00012345, 1, 4'd2, 32'h0, 8);
        rd(mb(15, 0), 32'h0400_0000, 8);
        rd(12'h000, 32'h0, 8);
        wr(12'h004, 32'hFFFF_FFFF);

        // R7 abort of a pending transmit
        wr(mb(20, 0), ctl(4'hC, 0, 0, 0, 4'd2));
        @(negedge clk);
        check(tx_valid == 1'b1 && tx_buf == 6'd20, 7, 32'(tx_buf), 32'd20);
        wr(mb(20, 0), 32'h0902_0000);
        rd(mb(20, 0), 32'h0802_0000, 7);
        @(negedge clk);
        check(tx_valid == 1'b0, 7, 32'(tx_valid), 32'd0);
        rd(12'h000, 32'h0, 7);

        // R12 unimplemented bits and undefined codes
        wr(mb(22, 0), 32'hF8FF_FFFF);
        rd(mb(22, 0), 32'h087F_0000, 12);
        wr(mb(23, 0), 32'h0100_0000);
        rd(mb(23, 0), 32'h0, 12);
        wr(mb(23, 0), 32'hFF00_0000);
        rd(mb(23, 0), 32'h0, 12);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, 1, 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule